// File: doc/BRIEF.md
# Tagged Half-Word Store Formatter

This block turns a store command into one write on a memory port whose words are 32 bits wide and whose two 16-bit halves can be written separately. A command carries the following:

- a 16-bit source value;
- a base word address taken from a register;
- a signed 11-bit byte offset;
- a 2-bit tag with its enable;
- the current program counter.

From these the block forms the word address, the write word and the two half enables.

Five command kinds are supported:

- stores to the low half of a word;
- stores to the high half of a word;
- full-word stores that pack the program counter and tag above the data;
- a command that loads a persistent auto-increment word offset;
- auto-increment stores, in a half-word form and a full-word form.

The half-word auto store fills the low half and then the high half of one word before moving on to the next word. The full-word auto store advances one word on every store.

Every command occupies the block for a fixed four cycles. The single write pulse comes in the last of those cycles. A new command is taken only while `cmd_ready` is high.

Top module: `tagged_store_formatter`

## Requirements
- R1: After reset `cmd_ready` is 1, `mem_we` is 0 and `mem_hen` is 0. The auto offset is 0 and the half selector points at the low half.
- R2: A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is then 0 for exactly 4 cycles. `mem_we` is 1 only in the 4th of those cycles, for one cycle, and `cmd_ready` returns to 1 in the following cycle.
- R3: Direct stores write to the address (`cmd_base` + floor(signed `cmd_offset` / 4)) modulo 2^ADDR_W. The direct stores are op 0 (low half), op 1 (high half) and op 2 (full word).
- R4: A low-half store drives `mem_hen` = 01 and places the half-word in `mem_wdata[15:0]`. A high-half store drives `mem_hen` = 10 and places it in `mem_wdata[31:16]`. The half that is not enabled is don't-care.
- R5: The stored half-word is {`cmd_tag`, `cmd_src[13:0]`} when `cmd_tag_en` is 1, and `cmd_src` when it is 0.
- R6: A full-word store (op 2 or op 5) drives `mem_hen` = 11. The write word is `cmd_pc[10:0]` in bits 31:21, zeros in bits 20:18, `cmd_tag` in bits 17:16 and `cmd_src` in bits 15:0. The tag enable is not used.
- R7: Op 3 (set offset) writes nothing. It loads the auto offset with floor(signed `cmd_offset` / 4) and returns the half selector to the low half.
- R8: Op 4 (half auto store) writes at (`cmd_base` + auto offset) modulo 2^ADDR_W, in the half named by the selector, formatted per R5. A low-half write moves the selector to the high half. A high-half write moves the selector back to the low half and adds one to the auto offset.
- R9: Op 5 (word auto store) writes a full word per R6 at (`cmd_base` + auto offset) modulo 2^ADDR_W. It then adds one to the auto offset and leaves the half selector unchanged.
- R10: Ops 6 and 7 are reserved. They take the same 4 cycles, write nothing, and leave the auto offset and the half selector unchanged.
- R11: A command presented while `cmd_ready` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command kind (0 lo, 1 hi, 2 word, 3 set offset, 4 auto half, 5 auto word) |
| cmd_src | input | 16 | Source value |
| cmd_base | input | ADDR_W | Base word address |
| cmd_offset | input | 11 | Signed byte offset (also the set-offset value) |
| cmd_tag | input | 2 | Tag |
| cmd_tag_en | input | 1 | Tag replaces the top two bits of a half store |
| cmd_pc | input | 11 | Program counter of the command |
| cmd_ready | output | 1 | Block can accept a command |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Memory write word |
| mem_hen | output | 2 | Half enables (bit 0 low, bit 1 high) |

## Verification
The assertions check the following on every cycle:

- the four-cycle occupancy and the single write in the last cycle;
- that idle cycles never disturb the auto offset or the half selector;
- that a high-half auto write advances the offset while a low-half one does not;
- that set-offset clears the selector;
- that reserved codes never reach the write port.

Only the bench scenarios can show the values themselves: the address arithmetic with negative offsets and wrap-around, the tag and program-counter packing, and the sequence of halves and words an auto-store chain visits after a set-offset.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int OFF_W  = 11;
  localparam int TAG_W  = 2;
  localparam int PC_W   = 11;
  localparam int HALF_W = 16;
  localparam int WORD_W = 32;
  localparam int PAD_W  = WORD_W - PC_W - TAG_W - HALF_W;

  typedef enum logic [2:0] {
    OP_STORE_LO   = 3'd0,
    OP_STORE_HI   = 3'd1,
    OP_STORE_WORD = 3'd2,
    OP_SET_STEP   = 3'd3,
    OP_AUTO_HALF  = 3'd4,
    OP_AUTO_WORD  = 3'd5,
    OP_RSVD_6     = 3'd6,
    OP_RSVD_7     = 3'd7
  } op_e;

  // byte offset to signed word offset (floor division by four)
  function automatic logic signed [OFF_W-1:0] word_step(input logic [OFF_W-1:0] byte_off);
    return $signed(byte_off) >>> 2;
  endfunction

  // half-word payload, optionally tagged in its two top bits
  function automatic logic [HALF_W-1:0] fmt_half(input logic [HALF_W-1:0] src,
                                                 input logic [TAG_W-1:0] tag,
                                                 input logic tag_en);
    return tag_en ? {tag, src[HALF_W-TAG_W-1:0]} : src;
  endfunction

  // full word: pc, zero pad, tag, data
  function automatic logic [WORD_W-1:0] fmt_word(input logic [PC_W-1:0] pc,
                                                 input logic [TAG_W-1:0] tag,
                                                 input logic [HALF_W-1:0] src);
    return {pc, {PAD_W{1'b0}}, tag, src};
  endfunction
endpackage

// File: rtl/tsf_sequencer.sv
module tsf_sequencer #(
  parameter int EXEC_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic commit
);
  localparam int CNT_W = (EXEC_CYC > 1) ? $clog2(EXEC_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(EXEC_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) busy <= 1'b0;
      else             cnt  <= cnt + 1'b1;
    end
  end

  assign commit = busy && (cnt == LAST);

  // R2: the commit cycle is the last busy cycle
  p_commit_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);
  // R2: a start always opens a busy window that does not commit at once
  p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !commit));
endmodule

// File: rtl/tsf_autoinc.sv
module tsf_autoinc
  import tsf_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  op_e               op,
  input  logic [OFF_W-1:0]  step_byte,
  output logic [ADDR_W-1:0] auto_off,
  output logic              half_hi
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_off <= '0;
      half_hi  <= 1'b0;
    end else if (commit) begin
      case (op)
        OP_SET_STEP: begin
          auto_off <= ADDR_W'(word_step(step_byte));
          half_hi  <= 1'b0;
        end
        OP_AUTO_HALF: begin
          if (half_hi) auto_off <= auto_off + 1'b1;
          half_hi <= ~half_hi;
        end
        OP_AUTO_WORD: auto_off <= auto_off + 1'b1;
        default: ;
      endcase
    end
  end

  // R8: after the high half the offset steps and the selector returns low
  p_step_after_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && op == OP_AUTO_HALF && half_hi) |=> (auto_off == $past(auto_off) + 1'b1) && !half_hi);
  // R8: the low half keeps the offset
  p_hold_after_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && op == OP_AUTO_HALF && !half_hi) |=> $stable(auto_off) && half_hi);
  // R7: set-offset clears the selector
  p_sel_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && op == OP_SET_STEP) |=> !half_hi);
  // R11: nothing changes without a commit
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(auto_off) && $stable(half_hi));
endmodule

// File: rtl/tsf_formatter.sv
module tsf_formatter
  import tsf_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  op_e               op,
  input  logic [HALF_W-1:0] src,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  byte_off,
  input  logic [TAG_W-1:0]  tag,
  input  logic              tag_en,
  input  logic [PC_W-1:0]   pc,
  input  logic [ADDR_W-1:0] auto_off,
  input  logic              half_hi,
  output logic              is_write,
  output logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] wdata,
  output logic [1:0]        hen
);
  logic [ADDR_W-1:0] addr_direct;
  logic [ADDR_W-1:0] addr_auto;
  logic [HALF_W-1:0] half_val;
  logic [WORD_W-1:0] word_val;

  assign addr_direct = base + ADDR_W'(word_step(byte_off));
  assign addr_auto   = base + auto_off;
  assign half_val    = fmt_half(src, tag, tag_en);
  assign word_val    = fmt_word(pc, tag, src);

  always_comb begin
    is_write = 1'b1;
    addr     = addr_direct;
    wdata    = {half_val, half_val};
    hen      = 2'b00;
    case (op)
      OP_STORE_LO:   hen = 2'b01;
      OP_STORE_HI:   hen = 2'b10;
      OP_STORE_WORD: begin hen = 2'b11; wdata = word_val; end
      OP_AUTO_HALF:  begin addr = addr_auto; hen = half_hi ? 2'b10 : 2'b01; end
      OP_AUTO_WORD:  begin addr = addr_auto; hen = 2'b11; wdata = word_val; end
      default:       is_write = 1'b0;
    endcase
  end
endmodule

// File: rtl/tagged_store_formatter.sv
module tagged_store_formatter
  import tsf_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int EXEC_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [15:0]       cmd_src,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [10:0]       cmd_offset,
  input  logic [1:0]        cmd_tag,
  input  logic              cmd_tag_en,
  input  logic [10:0]       cmd_pc,
  output logic              cmd_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [1:0]        mem_hen
);
  // named internal events
  logic start, busy, commit, is_write;
  logic [ADDR_W-1:0] auto_off, f_addr;
  logic              half_hi;
  logic [WORD_W-1:0] f_wdata;
  logic [1:0]        f_hen;

  // latched command
  op_e               op_q;
  logic [HALF_W-1:0] src_q;
  logic [ADDR_W-1:0] base_q;
  logic [OFF_W-1:0]  off_q;
  logic [TAG_W-1:0]  tag_q;
  logic              tag_en_q;
  logic [PC_W-1:0]   pc_q;

  assign cmd_ready = !busy;
  assign start     = cmd_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_RSVD_7;
      src_q    <= '0;
      base_q   <= '0;
      off_q    <= '0;
      tag_q    <= '0;
      tag_en_q <= 1'b0;
      pc_q     <= '0;
    end else if (start) begin
      op_q     <= op_e'(cmd_op);
      src_q    <= cmd_src;
      base_q   <= cmd_base;
      off_q    <= cmd_offset;
      tag_q    <= cmd_tag;
      tag_en_q <= cmd_tag_en;
      pc_q     <= cmd_pc;
    end
  end

  tsf_sequencer #(.EXEC_CYC(EXEC_CYC)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .commit(commit));

  tsf_autoinc #(.ADDR_W(ADDR_W)) auto_i (
    .clk(clk), .rst_n(rst_n), .commit(commit), .op(op_q), .step_byte(off_q),
    .auto_off(auto_off), .half_hi(half_hi));

  tsf_formatter #(.ADDR_W(ADDR_W)) fmt_i (
    .op(op_q), .src(src_q), .base(base_q), .byte_off(off_q), .tag(tag_q),
    .tag_en(tag_en_q), .pc(pc_q), .auto_off(auto_off), .half_hi(half_hi),
    .is_write(is_write), .addr(f_addr), .wdata(f_wdata), .hen(f_hen));

  assign mem_we    = commit && is_write;
  assign mem_addr  = mem_we ? f_addr  : '0;
  assign mem_wdata = mem_we ? f_wdata : '0;
  assign mem_hen   = mem_we ? f_hen   : 2'b00;

  // R2: a write happens only while busy and ends the window
  p_we_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (!cmd_ready ##1 cmd_ready));
  // R2: acceptance drops ready
  p_accept_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  // R4: a write always enables at least one half
  p_hen_present_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(mem_hen) != 0));
  // R1: no half enable without a write
  p_hen_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we |-> (mem_hen == 2'b00));
  // R10: reserved codes never reach the port
  p_rsvd_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (op_q != OP_RSVD_6 && op_q != OP_RSVD_7 && op_q != OP_SET_STEP));
  // R11: a command offered while busy does not replace the latched one
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> $stable(op_q) && $stable(src_q));
endmodule

// File: tb/tagged_store_formatter_tb_top.sv
`timescale 1ns/1ps
module tagged_store_formatter_tb_top;
  localparam int ADDR_W = 11;
  localparam int AMASK  = (1 << ADDR_W) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n, cmd_valid, cmd_tag_en, cmd_ready, mem_we;
  logic [2:0]        cmd_op;
  logic [15:0]       cmd_src;
  logic [ADDR_W-1:0] cmd_base, mem_addr;
  logic [10:0]       cmd_offset, cmd_pc;
  logic [1:0]        cmd_tag, mem_hen;
  logic [31:0]       mem_wdata;

  tagged_store_formatter dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_src(cmd_src), .cmd_base(cmd_base), .cmd_offset(cmd_offset),
    .cmd_tag(cmd_tag), .cmd_tag_en(cmd_tag_en), .cmd_pc(cmd_pc),
    .cmd_ready(cmd_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_hen(mem_hen));

  int checks = 0;
  int errors = 0;
  int m_off  = 0;
  bit m_hi   = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int floor_div4(input int v);
    int q;
    q = v / 4;
    if (v < 0 && (v % 4) != 0) q = q - 1;
    return q;
  endfunction

  // called at a falling edge with cmd_ready expected high
  task automatic run(input logic [2:0] op, input logic [15:0] src,
                     input logic [ADDR_W-1:0] base, input logic [10:0] off,
                     input logic [1:0] tag, input logic te,
                     input logic [10:0] pc, input bit noise, input string req);
    int so, hv, a;
    logic [31:0] ed, mask;
    logic [1:0]  eh;
    bit          ew;
    so = $signed(off);
    hv = te ? (int'(tag) * 16384 + int'(src) % 16384) : int'(src);
    ew = 1'b1; eh = 2'b00; ed = 32'h0; a = 0;
    case (op)
      3'd0: begin eh = 2'b01; ed = 32'(hv); a = int'(base) + floor_div4(so); end
      3'd1: begin eh = 2'b10; ed = 32'(hv) * 32'd65536; a = int'(base) + floor_div4(so); end
      3'd2: begin eh = 2'b11; a = int'(base) + floor_div4(so);
                  ed = 32'(pc) * 32'd2097152 + 32'(tag) * 32'd65536 + 32'(src); end
      3'd4: begin eh = m_hi ? 2'b10 : 2'b01; a = int'(base) + m_off;
                  ed = m_hi ? 32'(hv) * 32'd65536 : 32'(hv); end
      3'd5: begin eh = 2'b11; a = int'(base) + m_off;
                  ed = 32'(pc) * 32'd2097152 + 32'(tag) * 32'd65536 + 32'(src); end
      default: ew = 1'b0;
    endcase
    a = a & AMASK;
    mask = {{16{eh[1]}}, {16{eh[0]}}};
    chk(cmd_ready == 1'b1, "R2", "ready before command", 32'(cmd_ready), 32'd1);
    cmd_op = op; cmd_src = src; cmd_base = base; cmd_offset = off;
    cmd_tag = tag; cmd_tag_en = te; cmd_pc = pc; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (noise) begin
      // R11: a set-offset offered while busy must be dropped
      cmd_op = 3'd3; cmd_offset = 11'h1fc; cmd_valid = 1'b1;
    end else cmd_valid = 1'b0;
    for (int i = 1; i <= 4; i++) begin
      if (i > 1) @(negedge clk);
      if (i == 4) cmd_valid = 1'b0;
      chk(cmd_ready == 1'b0, "R2", "ready while busy", 32'(cmd_ready), 32'd0);
      chk(mem_we == (i == 4 && ew), (op >= 3'd6) ? "R10" : "R2", "write strobe",
          32'(mem_we), 32'(i == 4 && ew));
      if (i == 4 && ew) begin
        chk(int'(mem_addr) == a, req, "address", 32'(mem_addr), 32'(a));
        chk(mem_hen == eh, req, "half enables", 32'(mem_hen), 32'(eh));
        chk((mem_wdata & mask) == (ed & mask), req, "write data",
            mem_wdata & mask, ed & mask);
      end
    end
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R2", "ready after window", 32'(cmd_ready), 32'd1);
    case (op)
      3'd3: begin m_off = floor_div4(so) & AMASK; m_hi = 1'b0; end
      3'd4: begin if (m_hi) m_off = (m_off + 1) & AMASK; m_hi = ~m_hi; end
      3'd5: m_off = (m_off + 1) & AMASK;
      default: ;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_src = '0; cmd_base = '0;
    cmd_offset = '0; cmd_tag = '0; cmd_tag_en = 1'b0; cmd_pc = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_ready == 1'b1, "R1", "ready at reset", 32'(cmd_ready), 32'd1);
    chk(mem_we == 1'b0, "R1", "we at reset", 32'(mem_we), 32'd0);
    chk(mem_hen == 2'b00, "R1", "hen at reset", 32'(mem_hen), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: offset 0 and low half visible through first auto stores
    run(3'd4, 16'h1234, 11'h020, 11'h0, 2'd1, 1'b0, 11'h0, 1'b0, "R1");
    run(3'd5, 16'hbeef, 11'h020, 11'h0, 2'd2, 1'b0, 11'h155, 1'b0, "R9");

    // R3 R4 R5 R6: every byte offset through the direct stores
    for (int i = 0; i < 2048; i++) begin
      run(3'(i % 3), 16'((i * 37) ^ 16'ha5c3), 11'((i * 131) & AMASK), 11'(i),
          2'(i), 1'(i >> 2), 11'(i * 7), 1'b0,
          (i % 3 == 2) ? "R6" : ((i & 4) != 0 ? "R5" : "R3"));
    end

    // R7 R8 R9: auto chains after set-offset, including negative values
    for (int j = 0; j < 48; j++) begin
      logic [10:0] so;
      so = 11'((j * 173 + 5) & 11'h7ff);
      run(3'd3, 16'h0, 11'h0, so, 2'd0, 1'b0, 11'h0, 1'b0, "R7");
      for (int k = 0; k < 4; k++)
        run(3'd4, 16'(j * 1000 + k), 11'((j * 91) & AMASK), 11'h0, 2'(k), 1'(k),
            11'h0, 1'b0, "R8");
      run(3'd5, 16'(j), 11'((j * 91) & AMASK), 11'h0, 2'(j), 1'b0, 11'(j * 3),
          1'b0, "R9");
      // R7: set-offset in the middle of a pair returns to the low half
      run(3'd4, 16'h5a5a, 11'h7f0, 11'h0, 2'd3, 1'b1, 11'h0, 1'b0, "R8");
      run(3'd3, 16'h0, 11'h0, 11'h7f8, 2'd0, 1'b0, 11'h0, 1'b0, "R7");
      run(3'd4, 16'ha5a5, 11'h010, 11'h0, 2'd0, 1'b0, 11'h0, 1'b0, "R7");
      // R9: word auto store keeps the half selector
      run(3'd5, 16'h0f0f, 11'h010, 11'h0, 2'd1, 1'b0, 11'h3ff, 1'b0, "R9");
      run(3'd4, 16'hf0f0, 11'h010, 11'h0, 2'd0, 1'b0, 11'h0, 1'b0, "R9");
    end

    // R10: reserved codes leave the auto state alone
    run(3'd6, 16'hffff, 11'h7ff, 11'h7ff, 2'd3, 1'b1, 11'h7ff, 1'b0, "R10");
    run(3'd7, 16'hffff, 11'h7ff, 11'h004, 2'd3, 1'b1, 11'h7ff, 1'b0, "R10");
    run(3'd4, 16'h2222, 11'h100, 11'h0, 2'd0, 1'b0, 11'h0, 1'b0, "R10");
    run(3'd5, 16'h3333, 11'h100, 11'h0, 2'd0, 1'b0, 11'h0, 1'b0, "R10");

    // R11: commands offered while busy are dropped
    for (int n = 0; n < 8; n++)
      run(3'(n % 6), 16'(n * 4099), 11'(n * 17), 11'(n * 12), 2'(n), 1'(n),
          11'(n), 1'b1, "R11");
    run(3'd5, 16'h4444, 11'h200, 11'h0, 2'd0, 1'b0, 11'h0, 1'b0, "R11");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule